// File: doc/BRIEF.md
# Serial Sequential Read Shifter

This block is the read side of a three-wire serial memory slave. A host raises chip select, then clocks a command into the data input on rising edges of the serial clock: a start bit, a two-bit opcode and an eight-bit address. The block holds a 128-word by 16-bit array. When the command is a read and the protect select input is low, the block drives one zero bit and then the addressed word, most significant bit first. It keeps streaming the words that follow for as long as chip select stays high, and the address wraps from the top of the array back to zero.

When the protect select input is high, the same read opcode returns the eight-bit protect value instead. The output is a zero bit followed by that value, most significant bit first. The array is filled through a parallel write port. Serial write commands are handled by other logic.

The serial pins are sampled by a faster system clock. One clock cycle after the system clock sees a rising serial-clock edge, the output shows the bit for that edge. The output has a separate enable, which stands for the high-impedance state.

Top module: `serial_seq_reader`

## Requirements
- R1: A read frame is a start bit of 1, then opcode bits 1 and 0, then eight address bits, all sent most significant bit first. Any zero bits that arrive before the start bit are ignored.
- R2: The top address bit has no effect. The seven lower address bits select one of the 128 words.
- R3: The serial-clock rise that samples the last address bit of a valid read turns the output enable on and drives a 0 dummy bit.
- R4: Each array word is sent as 16 bits, most significant first. The output moves to the next bit one system clock after a serial-clock rise and holds at all other times.
- R5: With protect select low at decode, the block sends word n+1, n+2 and so on after word n, with no new command, for as long as chip select stays high. After address 0x7F it continues at 0x00.
- R6: With protect select high at decode, the read returns a 0 dummy bit, then the 8-bit protect value, most significant first. The output enable turns off on the next serial-clock rise.
- R7: The output enable is low while chip select is low, during command input, and in the cycle after chip select is seen low.
- R8: Chip select going low discards any partial command. The next command needs a new start bit.
- R9: An opcode other than binary 10 produces no output until chip select goes low.
- R10: A parallel write with memWe high stores memWdata at memAddr. A later serial read returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data input |
| pre | input | 1 | Protect select; high selects the protect-value read |
| protVal | input | 8 | Current protect value |
| memWe | input | 1 | Parallel array write enable |
| memAddr | input | 7 | Parallel array write address |
| memWdata | input | 16 | Parallel array write data |
| doData | output | 1 | Serial data output |
| doOe | output | 1 | Output enable; low means high-impedance |

## Verification
The assertions assume that cs, sk and di are already synchronous to clk. They also assume that each level of sk lasts at least one system clock, so that every serial-clock rise is seen exactly once. The bench meets these assumptions by changing the serial pins only on falling clk edges and by holding each sk phase for several cycles. It samples the output after the rise has settled and again just before the next rise, which checks both the update edge and the hold between edges. Addresses, word counts and protect values come from a seeded random source. Directed cases add the wrap at 0x7F, leading zeros before the start bit, an aborted frame and illegal opcodes.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_SEQ,
    ST_PROT,
    ST_SKIP
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadWord;
    logic loadProt;
    logic shiftOut;
    logic nextWord;
  } dpStrobe_t;

  localparam int OPC_W = 2;
  localparam logic [OPC_W-1:0] OPC_READ = 2'b10;

endpackage

// File: rtl/srs_array.sv
module srs_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [DATA_W-1:0] rData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
  end

  assign rData = mem[rAddr];
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int CMD_ADDR_W = 8,
  parameter int DATA_W     = 16,
  parameter int PROT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             sk,
  input  logic             di,
  input  logic             pre,
  input  logic [OPC_W-1:0] opcode,
  output dpStrobe_t        strobe,
  output logic             outEn
);
  localparam int CNT_W = $clog2(DATA_W + CMD_ADDR_W + PROT_W);

  ctlState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             skPrev;
  logic             skRise;

  assign skRise = cs && sk && !skPrev;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextCnt   = cnt;
    if (skRise) begin
      unique case (state)
        ST_IDLE: begin
          if (di) begin
            nextState = ST_OPC;
            nextCnt   = '0;
          end
        end
        ST_OPC: begin
          strobe.shiftIn = 1'b1;
          if (cnt == CNT_W'(OPC_W - 1)) begin
            nextState = ST_ADDR;
            nextCnt   = '0;
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
        ST_ADDR: begin
          strobe.shiftIn = 1'b1;
          if (cnt == CNT_W'(CMD_ADDR_W - 1)) begin
            nextCnt = '0;
            if (opcode != OPC_READ) begin
              nextState = ST_SKIP;
            end else if (pre) begin
              nextState       = ST_PROT;
              strobe.loadProt = 1'b1;
            end else begin
              nextState       = ST_SEQ;
              strobe.loadWord = 1'b1;
            end
          end else begin
            nextCnt = cnt + 1'b1;
          end
        end
        ST_SEQ: begin
          if (cnt == CNT_W'(DATA_W - 1)) begin
            strobe.nextWord = 1'b1;
            nextCnt         = '0;
          end else begin
            strobe.shiftOut = 1'b1;
            nextCnt         = cnt + 1'b1;
          end
        end
        ST_PROT: begin
          if (cnt == CNT_W'(PROT_W)) begin
            nextState = ST_SKIP;
          end else begin
            strobe.shiftOut = 1'b1;
            nextCnt         = cnt + 1'b1;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      skPrev <= 1'b0;
    end else begin
      skPrev <= sk;
      if (!cs) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        state <= nextState;
        cnt   <= nextCnt;
      end
    end
  end

  assign outEn = cs && ((state == ST_SEQ) || (state == ST_PROT));
endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int CMD_ADDR_W = 8,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int PROT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              di,
  input  dpStrobe_t         strobe,
  input  logic [PROT_W-1:0] protVal,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [OPC_W-1:0]  opcode,
  output logic              doData
);
  localparam int SR_W  = OPC_W + CMD_ADDR_W - 1;
  localparam int PAD_W = DATA_W - PROT_W;

  logic [SR_W-1:0]   cmdSr;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] newAddr;
  logic [DATA_W-1:0] outSr;
  logic              doBit;

  // the address MSB drops out here; lower bits plus the bit in flight
  assign newAddr = {cmdSr[ADDR_W-2:0], di};
  assign opcode  = cmdSr[SR_W-1 -: OPC_W];
  assign rdAddr  = strobe.loadWord ? newAddr : addr + 1'b1;
  assign doData  = doBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdSr <= '0;
      addr  <= '0;
      outSr <= '0;
      doBit <= 1'b0;
    end else begin
      if (strobe.shiftIn) cmdSr <= {cmdSr[SR_W-2:0], di};
      if (strobe.loadWord) begin
        addr  <= newAddr;
        outSr <= rdData;
        doBit <= 1'b0;
      end else if (strobe.loadProt) begin
        outSr <= {protVal, {PAD_W{1'b0}}};
        doBit <= 1'b0;
      end else if (strobe.nextWord) begin
        doBit <= outSr[DATA_W-1];
        addr  <= addr + 1'b1;
        outSr <= rdData;
      end else if (strobe.shiftOut) begin
        doBit <= outSr[DATA_W-1];
        outSr <= {outSr[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/serial_seq_reader.sv
module serial_seq_reader
  import srs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int PROT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  input  logic              pre,
  input  logic [PROT_W-1:0] protVal,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWdata,
  output logic              doData,
  output logic              doOe
);
  localparam int CMD_ADDR_W = ADDR_W + 1;

  dpStrobe_t         strobe;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdData;

  srs_ctrl #(
    .CMD_ADDR_W(CMD_ADDR_W),
    .DATA_W    (DATA_W),
    .PROT_W    (PROT_W)
  ) uCtrl (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .sk    (sk),
    .di    (di),
    .pre   (pre),
    .opcode(opcode),
    .strobe(strobe),
    .outEn (doOe)
  );

  srs_datapath #(
    .CMD_ADDR_W(CMD_ADDR_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PROT_W    (PROT_W)
  ) uDp (
    .clk    (clk),
    .rst_n  (rst_n),
    .di     (di),
    .strobe (strobe),
    .protVal(protVal),
    .rdData (rdData),
    .rdAddr (rdAddr),
    .opcode (opcode),
    .doData (doData)
  );

  srs_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uArray (
    .clk  (clk),
    .we   (memWe),
    .wAddr(memAddr),
    .wData(memWdata),
    .rAddr(rdAddr),
    .rData(rdData)
  );
endmodule

// File: rtl/srs_checker.sv
module srs_checker (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sk,
  input logic doData,
  input logic doOe
);
  logic [1:0] warmCnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end
  assign warm = (warmCnt == 2'd3);

  AST_DUMMY_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $rose(doOe)) |-> (doData == 1'b0)); // R3

  AST_OE_ON_SK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $rose(doOe)) |-> ($past(sk) && !$past(sk, 2))); // R3

  AST_OE_DROPS_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !cs) |=> !doOe); // R7

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $rose(doOe)) |-> ($past(cs) && cs)); // R7

  AST_DO_HOLDS_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(cs) && !($past(sk) && !$past(sk, 2))) |-> $stable(doData)); // R4
endmodule

bind serial_seq_reader srs_checker uChk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs    (cs),
  .sk    (sk),
  .doData(doData),
  .doOe  (doOe)
);

// File: tb/serial_seq_reader_test.sv
module serial_seq_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic        sk = 1'b0;
  logic        di = 1'b0;
  logic        pre = 1'b0;
  logic [7:0]  protVal = 8'h00;
  logic        memWe = 1'b0;
  logic [6:0]  memAddr = '0;
  logic [15:0] memWdata = '0;
  logic        doData;
  logic        doOe;

  logic [15:0] shadow [128];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  serial_seq_reader uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .pre(pre),
    .protVal(protVal), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .doData(doData), .doOe(doOe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic loadMem(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    memWe = 1'b1; memAddr = a; memWdata = d; shadow[a] = d;
    @(negedge clk);
    memWe = 1'b0;
  endtask

  task automatic sendBit(input logic b, output logic preVal,
                         output logic postVal, output logic postOe);
    @(negedge clk);
    di = b;
    repeat (2) @(negedge clk);
    preVal = doData;
    sk = 1'b1;
    repeat (3) @(negedge clk);
    postVal = doData;
    postOe = doOe;
    sk = 1'b0;
  endtask

  task automatic csHigh();
    @(negedge clk);
    cs = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic csLow();
    @(negedge clk);
    cs = 1'b0; sk = 1'b0;
    repeat (3) @(negedge clk);
    check(doOe == 1'b0, "R7", "oe after cs low", doOe, 0);
  endtask

  // sends start, opcode, address; checks oe stays low until the last bit
  task automatic sendCmd(input logic [1:0] opc, input logic [7:0] a,
                         output logic lastVal, output logic lastOe);
    logic [10:0] frame;
    logic pv, v, oe;
    bit quiet;
    frame = {1'b1, opc, a};
    quiet = 1'b1;
    for (int i = 10; i >= 0; i--) begin
      sendBit(frame[i], pv, v, oe);
      if (i > 0 && oe) quiet = 1'b0;
      lastVal = v;
      lastOe = oe;
    end
    check(quiet, "R7", "oe low during command", 0, 0);
  endtask

  task automatic readWords(input logic [7:0] a, input int nWords, input int leadZeros);
    logic v, oe, pv, prevV;
    logic [15:0] got;
    logic [6:0] wa;
    bit held;
    pre = 1'b0;
    csHigh();
    for (int z = 0; z < leadZeros; z++) begin
      sendBit(1'b0, pv, v, oe);
      check(oe == 1'b0, "R1", "oe during leading zero", oe, 0);
    end
    sendCmd(2'b10, a, v, oe);
    check(oe == 1'b1 && v == 1'b0, "R3", "dummy bit", {oe, v}, 2'b10);
    prevV = v;
    for (int w = 0; w < nWords; w++) begin
      wa = a[6:0] + 7'(w);
      held = 1'b1;
      for (int b = 15; b >= 0; b--) begin
        sendBit(1'($urandom_range(0, 1)), pv, v, oe);
        if (pv !== prevV || !oe) held = 1'b0;
        got[b] = v;
        prevV = v;
      end
      check(held, "R4", "output held between sk rises", 0, 0);
      if (w == 0)
        check(got == shadow[wa], (leadZeros > 0) ? "R1" : "R2", "first word", got, shadow[wa]);
      else
        check(got == shadow[wa], "R5", "sequential word", got, shadow[wa]);
    end
    csLow();
  endtask

  task automatic readProt(input logic [7:0] pv8);
    logic v, oe, pv;
    logic [7:0] got;
    protVal = pv8;
    pre = 1'b1;
    csHigh();
    sendCmd(2'b10, 8'($urandom_range(0, 255)), v, oe);
    check(oe == 1'b1 && v == 1'b0, "R6", "protect dummy bit", {oe, v}, 2'b10);
    for (int b = 7; b >= 0; b--) begin
      sendBit(1'b0, pv, v, oe);
      got[b] = v;
    end
    check(got == pv8, "R6", "protect value", got, pv8);
    sendBit(1'b0, pv, v, oe);
    check(oe == 1'b0, "R6", "oe off after protect value", oe, 0);
    csLow();
    pre = 1'b0;
  endtask

  task automatic badOpcode(input logic [1:0] opc);
    logic v, oe, pv;
    bit quiet;
    pre = 1'($urandom_range(0, 1));
    csHigh();
    sendCmd(opc, 8'($urandom_range(0, 255)), v, oe);
    quiet = !oe;
    for (int i = 0; i < 20; i++) begin
      sendBit(1'($urandom_range(0, 1)), pv, v, oe);
      if (oe) quiet = 1'b0;
    end
    check(quiet, "R9", "no output for other opcode", opc, 0);
    csLow();
    pre = 1'b0;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", WDOG_CYCLES);
      summary();
      $finish;
    end
  end

  initial begin
    logic v, oe, pv;
    void'($urandom(32'd24680));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(doOe == 1'b0 && doData == 1'b0, "R7", "reset state", {doOe, doData}, 0);

    for (int i = 0; i < 128; i++) loadMem(7'(i), 16'($urandom()));

    // random reads, top address bit random
    for (int i = 0; i < 6; i++)
      readWords(8'($urandom_range(0, 255)), $urandom_range(1, 3), 0);

    // address bit 7 set vs clear on the same word
    readWords(8'h95, 1, 0);
    readWords(8'h15, 1, 0);

    // wrap from the top of the array
    readWords(8'hFF, 2, 0);
    readWords(8'h7E, 3, 0);

    // leading zeros before the start bit
    readWords(8'($urandom_range(0, 255)), 1, 3);

    // parallel write then read back
    loadMem(7'h2A, 16'hA5C3);
    readWords(8'h2A, 1, 0);
    check(shadow[7'h2A] == 16'hA5C3, "R10", "shadow updated", shadow[7'h2A], 16'hA5C3);

    // protect value reads
    readProt(8'h00);
    readProt(8'hFF);
    readProt(8'($urandom_range(0, 255)));

    // illegal opcodes
    badOpcode(2'b11);
    badOpcode(2'b01);
    badOpcode(2'b00);

    // aborted frame, then a clean frame (R8)
    csHigh();
    sendBit(1'b1, pv, v, oe);
    sendBit(1'b1, pv, v, oe);
    sendBit(1'b0, pv, v, oe);
    for (int i = 0; i < 4; i++) sendBit(1'b1, pv, v, oe);
    check(oe == 1'b0, "R8", "oe during partial frame", oe, 0);
    csLow();
    readWords(8'h33, 1, 0);

    // abort mid-stream, then restart at a new address (R8)
    readWords(8'h40, 1, 0);
    readWords(8'h05, 2, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule